// File: doc/BRIEF.md
# Console Terminal Register Interface

This block gives a processor a four-register view of a console serial link. A narrow register bus (two-bit address, read and write strobes, 16-bit data) reaches one control/status register and one data register for each direction. Characters arrive from a byte-stream receive port that may also flag a framing error or a line break. Characters leave through a byte-stream transmit port with a valid/ready handshake. Each direction keeps a done flag and an interrupt-enable flag and drives its own level-sensitive interrupt request.

The receive data register carries the character in its low byte and error flags in its high byte. Reading it consumes the character: done drops, the error flags clear and the interrupt is withdrawn. A break arriving while the halt-enable input is high also produces a one-cycle halt request. Writing the transmit data register starts a transfer that stays offered on the port until the port accepts it. Read data is combinational from current state while the read strobe is high; all side effects take place at the clock edge that ends the access.

Top module: `con_term_regs`

## Requirements
- R1: Address 0 is receive control, 1 receive data, 2 transmit control, 3 transmit data. A control register reads done at bit 7 and interrupt-enable at bit 6, with all other bits 0. A write changes only interrupt-enable (from bit 6 of the write data); done cannot be written.
- R2: After reset, receive control reads 0x0000, receive data reads 0x0000, transmit control reads 0x0080, both interrupt requests are low, and the transmit port and halt request are idle.
- R3: A control register write with bit 6 at 0 leaves that direction's interrupt request low from the next cycle.
- R4: A control register write with bit 6 at 1, while done is 1 and interrupt-enable was 0, raises that direction's interrupt request in the next cycle. An interrupt request is only ever high while its done and interrupt-enable are both 1.
- R5: A receive-port character stores its 8 bits in the low byte of the receive data register, sets receive done, and raises the receive interrupt if interrupt-enable is 1.
- R6: A read of the receive data register returns the full word, then clears receive done, clears bits 15:8 (keeping the character) and lowers the receive interrupt, unless a new character arrives in that same cycle, in which case the new character is stored.
- R7: A break on the receive port stores 0xA400 (bit 15 any-error, bit 13 framing, bit 10 break, character 0) and, if halt-enable is high, drives halt request high for exactly one cycle; with halt-enable low no halt request occurs.
- R8: A character flagged with a framing error is stored with bits 15 and 13 set above the character.
- R9: A character arriving while receive done is still 1 and not being read in that cycle is stored with bits 15 and 14 (overrun) set.
- R10: A write to the transmit data register latches bits 7:0, clears transmit done, lowers the transmit interrupt and offers the byte on the transmit port from the next cycle.
- R11: While the transmit port holds ready low the byte stays offered unchanged and done stays 0; on the cycle the port takes it, transmit done sets, the offer ends and the transmit interrupt rises if enabled.
- R12: Read data is 0 when the read strobe is low; reading transmit data returns 0; writes to the receive data register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high |
| rx_valid | input | 1 | Receive port has a character this cycle |
| rx_data | input | 8 | Received character |
| rx_ferr | input | 1 | Received character had a framing error |
| rx_break | input | 1 | Receive event is a line break |
| halt_en | input | 1 | Allows a break to request a halt |
| halt_req | output | 1 | One-cycle halt request |
| rx_irq | output | 1 | Receive interrupt request, level |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit port takes the byte |
| tx_irq | output | 1 | Transmit interrupt request, level |

## Verification
A corrupted done or interrupt-enable flag shows on the next control register read and, through the interrupt outputs, in the very cycle after the edge that corrupted it, since each request is forced to follow done and enable. A wrong error-flag update surfaces only when software reads the receive data word, so the bench reads that word immediately after every overrun, framing and break event and again after the consuming read. Transmit-side faults show on the port within one cycle of the data write or of the accepting handshake, and a stalled port is held for several cycles to expose a byte or done flag that drifts.

// File: rtl/con_term_pkg.sv
package con_term_pkg;

    localparam int DATA_W  = 16;
    localparam int CHAR_W  = 8;
    localparam int ADDR_W  = 2;

    localparam int DONE_BIT = 7;
    localparam int IE_BIT   = 6;
    localparam int ERR_ANY  = 15;
    localparam int ERR_OVR  = 14;
    localparam int ERR_FRM  = 13;
    localparam int ERR_BRK  = 10;

    typedef enum logic [ADDR_W-1:0] {
        SEL_RX_CTL = 2'd0,
        SEL_RX_BUF = 2'd1,
        SEL_TX_CTL = 2'd2,
        SEL_TX_BUF = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic done;
        logic ie;
    } ctl_bits_t;

    typedef struct packed {
        logic any;
        logic ovr;
        logic frm;
        logic brk;
    } rx_err_t;

    typedef struct packed {
        rx_err_t            err;
        logic [CHAR_W-1:0]  chr;
    } rx_word_t;

    typedef struct packed {
        logic               rx_ctl_wr;
        logic               rx_buf_rd;
        logic               tx_ctl_wr;
        logic               tx_buf_wr;
        logic               ie_val;
        logic [CHAR_W-1:0]  wr_char;
    } bus_cmd_t;

    function automatic logic [DATA_W-1:0] ctl_word(input ctl_bits_t c);
        logic [DATA_W-1:0] r;
        r           = '0;
        r[DONE_BIT] = c.done;
        r[IE_BIT]   = c.ie;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] rx_word_pack(input rx_word_t w);
        logic [DATA_W-1:0] r;
        r             = '0;
        r[CHAR_W-1:0] = w.chr;
        r[ERR_ANY]    = w.err.any;
        r[ERR_OVR]    = w.err.ovr;
        r[ERR_FRM]    = w.err.frm;
        r[ERR_BRK]    = w.err.brk;
        return r;
    endfunction

    // interrupt update on a control write: clear when disabled, raise on a
    // 0->1 enable edge with done already set, otherwise keep
    function automatic logic irq_on_ctl_wr(input logic irq_cur, input ctl_bits_t c,
                                           input logic ie_new);
        logic r;
        r = irq_cur;
        if (!ie_new)
            r = 1'b0;
        else if (c.done && !c.ie)
            r = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/con_term_decode.sv
module con_term_decode
    import con_term_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  ctl_bits_t         rx_ctl,
    input  rx_word_t          rx_word,
    input  ctl_bits_t         tx_ctl,
    output bus_cmd_t          cmd,
    output logic [DATA_W-1:0] bus_rdata
);
    reg_sel_e sel;
    logic     wdata_unused_hi;

    assign sel             = reg_sel_e'(bus_addr);
    assign wdata_unused_hi = ^bus_wdata[DATA_W-1:CHAR_W];

    always_comb begin
        cmd           = '0;
        cmd.ie_val    = bus_wdata[IE_BIT];
        cmd.wr_char   = bus_wdata[CHAR_W-1:0];
        cmd.rx_ctl_wr = bus_wr && (sel == SEL_RX_CTL);
        cmd.tx_ctl_wr = bus_wr && (sel == SEL_TX_CTL);
        cmd.tx_buf_wr = bus_wr && (sel == SEL_TX_BUF);
        cmd.rx_buf_rd = bus_rd && (sel == SEL_RX_BUF);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_RX_CTL: bus_rdata = ctl_word(rx_ctl);
                SEL_RX_BUF: bus_rdata = rx_word_pack(rx_word);
                SEL_TX_CTL: bus_rdata = ctl_word(tx_ctl);
                SEL_TX_BUF: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/con_term_rx.sv
module con_term_rx
    import con_term_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ie_val,
    input  logic              buf_rd,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_ferr,
    input  logic              rx_break,
    input  logic              halt_en,
    output ctl_bits_t         ctl,
    output rx_word_t          word,
    output logic              irq,
    output logic              halt_req
);
    ctl_bits_t ctl_n;
    rx_word_t  word_n;
    logic      irq_n;

    always_comb begin
        ctl_n  = ctl;
        word_n = word;
        irq_n  = irq;
        if (ctl_wr) begin
            irq_n    = irq_on_ctl_wr(irq, ctl, ie_val);
            ctl_n.ie = ie_val;
        end
        if (buf_rd) begin
            ctl_n.done = 1'b0;
            word_n.err = '0;
            irq_n      = 1'b0;
        end
        if (rx_valid) begin
            word_n.chr     = rx_break ? '0 : rx_data;
            word_n.err.brk = rx_break;
            word_n.err.frm = rx_break || rx_ferr;
            word_n.err.ovr = ctl.done && !buf_rd;
            word_n.err.any = rx_break || rx_ferr || (ctl.done && !buf_rd);
            ctl_n.done     = 1'b1;
            if (ctl_n.ie)
                irq_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= '0;
            word     <= '0;
            irq      <= 1'b0;
            halt_req <= 1'b0;
        end else begin
            ctl      <= ctl_n;
            word     <= word_n;
            irq      <= irq_n;
            halt_req <= rx_valid && rx_break && halt_en;
        end
    end
endmodule

// File: rtl/con_term_tx.sv
module con_term_tx
    import con_term_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ie_val,
    input  logic              buf_wr,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              tx_ready,
    output ctl_bits_t         ctl,
    output logic              irq,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data
);
    ctl_bits_t         ctl_n;
    logic              irq_n;
    logic              pend_n;
    logic [CHAR_W-1:0] data_n;

    always_comb begin
        ctl_n  = ctl;
        irq_n  = irq;
        pend_n = tx_valid;
        data_n = tx_data;
        if (ctl_wr) begin
            irq_n    = irq_on_ctl_wr(irq, ctl, ie_val);
            ctl_n.ie = ie_val;
        end
        if (tx_valid && tx_ready) begin
            pend_n     = 1'b0;
            ctl_n.done = 1'b1;
            if (ctl_n.ie)
                irq_n = 1'b1;
        end
        if (buf_wr) begin
            data_n     = wr_char;
            pend_n     = 1'b1;
            ctl_n.done = 1'b0;
            irq_n      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= '{done: 1'b1, ie: 1'b0};
            irq      <= 1'b0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            ctl      <= ctl_n;
            irq      <= irq_n;
            tx_valid <= pend_n;
            tx_data  <= data_n;
        end
    end
endmodule

// File: rtl/con_term_regs.sv
module con_term_regs
    import con_term_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_ferr,
    input  logic        rx_break,
    input  logic        halt_en,
    output logic        halt_req,
    output logic        rx_irq,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    output logic        tx_irq
);
    bus_cmd_t  cmd;
    ctl_bits_t rx_ctl;
    ctl_bits_t tx_ctl;
    rx_word_t  rx_word;

    con_term_decode u_decode (
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .rx_ctl    (rx_ctl),
        .rx_word   (rx_word),
        .tx_ctl    (tx_ctl),
        .cmd       (cmd),
        .bus_rdata (bus_rdata)
    );

    con_term_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (cmd.rx_ctl_wr),
        .ie_val   (cmd.ie_val),
        .buf_rd   (cmd.rx_buf_rd),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ferr  (rx_ferr),
        .rx_break (rx_break),
        .halt_en  (halt_en),
        .ctl      (rx_ctl),
        .word     (rx_word),
        .irq      (rx_irq),
        .halt_req (halt_req)
    );

    con_term_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (cmd.tx_ctl_wr),
        .ie_val   (cmd.ie_val),
        .buf_wr   (cmd.tx_buf_wr),
        .wr_char  (cmd.wr_char),
        .tx_ready (tx_ready),
        .ctl      (tx_ctl),
        .irq      (tx_irq),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );
endmodule

// File: rtl/con_term_regs_chk.sv
module con_term_regs_chk
    import con_term_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [1:0]  bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        rx_valid,
    input logic        rx_break,
    input logic        halt_en,
    input logic        halt_req,
    input logic        rx_irq,
    input logic        tx_valid,
    input logic [7:0]  tx_data,
    input logic        tx_ready,
    input logic        tx_irq,
    input ctl_bits_t   rx_ctl,
    input ctl_bits_t   tx_ctl
);
    logic tx_wr_now;
    assign tx_wr_now = bus_wr && (bus_addr == 2'd3);

    // R3
    rx_ie_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && !bus_wdata[IE_BIT]) |=> !rx_irq);

    // R3
    tx_ie_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd2 && !bus_wdata[IE_BIT]) |=> !tx_irq);

    // R4
    rx_irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (rx_ctl.done && rx_ctl.ie));

    // R4
    tx_irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> (tx_ctl.done && tx_ctl.ie));

    // R5
    rx_done_set_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> rx_ctl.done);

    // R6
    rx_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd1 && !rx_valid) |=> (!rx_ctl.done && !rx_irq));

    // R7
    halt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_break && halt_en) |=> halt_req);

    // R7
    halt_only_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_break && halt_en) |=> !halt_req);

    // R10
    tx_start_chk: assert property (@(posedge clk) disable iff (rst)
        tx_wr_now |=> (tx_valid && !tx_irq && !tx_ctl.done));

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !tx_wr_now) |=> (tx_valid && $stable(tx_data) && !tx_ctl.done));

    // R11
    tx_done_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !tx_wr_now) |=> (tx_ctl.done && !tx_valid));

    // R12
    rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == 16'h0000));
endmodule

bind con_term_regs con_term_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rx_valid  (rx_valid),
    .rx_break  (rx_break),
    .halt_en   (halt_en),
    .halt_req  (halt_req),
    .rx_irq    (rx_irq),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .tx_irq    (tx_irq),
    .rx_ctl    (rx_ctl),
    .tx_ctl    (tx_ctl)
);

// File: tb/con_term_regs_bench.sv
module con_term_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ferr = 1'b0;
    logic        rx_break = 1'b0;
    logic        halt_en = 1'b0;
    logic        halt_req;
    logic        rx_irq;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        tx_irq;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 1'b0;

    localparam logic [1:0] A_RXC = 2'd0, A_RXD = 2'd1, A_TXC = 2'd2, A_TXD = 2'd3;

    always #2 clk = ~clk;

    con_term_regs u_con_term_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_break(rx_break), .halt_en(halt_en),
        .halt_req(halt_req), .rx_irq(rx_irq), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .tx_irq(tx_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] c, input logic ferr, input logic brk);
        rx_data = c; rx_ferr = ferr; rx_break = brk; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_ferr = 1'b0; rx_break = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        bus_read(A_RXC, d); check("R2", "rx ctl after reset", d, 16'h0000);
        bus_read(A_RXD, d); check("R2", "rx data after reset", d, 16'h0000);
        bus_read(A_TXC, d); check("R2", "tx ctl after reset", d, 16'h0080);
        check("R2", "irqs after reset", {14'd0, rx_irq, tx_irq}, 16'h0000);
        check("R2", "tx offer and halt after reset", {14'd0, tx_valid, halt_req}, 16'h0000);
    endtask

    task automatic t_rx_basic();
        logic [15:0] d;
        rx_send(8'h41, 1'b0, 1'b0);
        bus_read(A_RXC, d); check("R5", "rx done set, ie clear", d, 16'h0080);
        check("R5", "no irq with ie 0", {15'd0, rx_irq}, 16'h0000);
        bus_read(A_RXD, d); check("R5", "rx char", d, 16'h0041);
        bus_read(A_RXC, d); check("R6", "done cleared by read", d, 16'h0000);
        bus_read(A_RXD, d); check("R6", "char kept after read", d, 16'h0041);
    endtask

    task automatic t_rx_enable();
        logic [15:0] d;
        bus_write(A_RXC, 16'h00FF);
        bus_read(A_RXC, d); check("R1", "only ie writable, done 0", d, 16'h0040);
        bus_write(A_RXC, 16'h0000);
        rx_send(8'h42, 1'b0, 1'b0);
        check("R4", "no irq before enable", {15'd0, rx_irq}, 16'h0000);
        bus_write(A_RXC, 16'h0040);
        check("R4", "irq on late enable", {15'd0, rx_irq}, 16'h0001);
        bus_write(A_RXC, 16'hFFBF);
        check("R3", "irq dropped by ie 0", {15'd0, rx_irq}, 16'h0000);
        bus_read(A_RXC, d); check("R1", "done kept, ie 0", d, 16'h0080);
        bus_write(A_RXC, 16'h0040);
        check("R4", "irq raised again", {15'd0, rx_irq}, 16'h0001);
        bus_read(A_RXD, d); check("R6", "char read", d, 16'h0042);
        check("R6", "irq dropped by read", {15'd0, rx_irq}, 16'h0000);
    endtask

    task automatic t_overrun();
        logic [15:0] d;
        rx_send(8'h10, 1'b0, 1'b0);
        check("R5", "irq with ie 1", {15'd0, rx_irq}, 16'h0001);
        rx_send(8'h20, 1'b0, 1'b0);
        bus_read(A_RXD, d); check("R9", "overrun word", d, 16'hC020);
        bus_read(A_RXD, d); check("R6", "errors cleared", d, 16'h0020);
        check("R6", "irq low after read", {15'd0, rx_irq}, 16'h0000);
        rx_send(8'h55, 1'b1, 1'b0);
        bus_read(A_RXD, d); check("R8", "framing word", d, 16'hA055);
    endtask

    task automatic t_break();
        logic [15:0] d;
        halt_en = 1'b1;
        rx_send(8'h33, 1'b0, 1'b1);
        check("R7", "halt pulse", {15'd0, halt_req}, 16'h0001);
        @(negedge clk);
        check("R7", "halt one cycle", {15'd0, halt_req}, 16'h0000);
        bus_read(A_RXD, d); check("R7", "break word", d, 16'hA400);
        halt_en = 1'b0;
        rx_send(8'h33, 1'b0, 1'b1);
        check("R7", "no halt when disabled", {15'd0, halt_req}, 16'h0000);
        bus_read(A_RXD, d); check("R7", "break word again", d, 16'hA400);
        bus_write(A_RXC, 16'h0000);
    endtask

    task automatic t_tx();
        logic [15:0] d;
        bus_write(A_TXC, 16'h0040);
        check("R4", "tx irq on enable with done", {15'd0, tx_irq}, 16'h0001);
        bus_write(A_TXD, 16'h01A5);
        check("R10", "tx offered", {15'd0, tx_valid}, 16'h0001);
        check("R10", "tx byte", {8'd0, tx_data}, 16'h00A5);
        check("R10", "tx irq dropped", {15'd0, tx_irq}, 16'h0000);
        bus_read(A_TXC, d); check("R10", "tx done cleared", d, 16'h0040);
        repeat (3) @(negedge clk);
        check("R11", "held under stall", {7'd0, tx_valid, tx_data}, 16'h01A5);
        bus_read(A_TXC, d); check("R11", "done low under stall", d, 16'h0040);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        check("R11", "offer ends", {15'd0, tx_valid}, 16'h0000);
        check("R11", "tx irq on accept", {15'd0, tx_irq}, 16'h0001);
        bus_read(A_TXC, d); check("R11", "tx done set", d, 16'h00C0);
        bus_write(A_TXC, 16'h0000);
        check("R3", "tx irq dropped by ie 0", {15'd0, tx_irq}, 16'h0000);
    endtask

    task automatic t_misc();
        logic [15:0] d;
        rx_send(8'h77, 1'b0, 1'b0);
        bus_addr = A_RXD; bus_rd = 1'b0;
        #1 check("R12", "rdata idle", bus_rdata, 16'h0000);
        @(negedge clk);
        bus_write(A_RXD, 16'hFFFF);
        bus_read(A_RXC, d); check("R12", "rx ctl unchanged by data write", d, 16'h0080);
        bus_read(A_RXD, d); check("R12", "rx data unchanged by data write", d, 16'h0077);
        bus_read(A_TXD, d); check("R12", "tx data reads 0", d, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rx_basic();
        t_rx_enable();
        t_overrun();
        t_break();
        t_tx();
        t_misc();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule